// File: doc/BRIEF.md
# Performance Event Counter Bank with Shared Word Storage

This block keeps a bank of wide event counters for hardware performance monitoring while holding only a few bits of each counter in flip-flops. Every counter owns a 7-bit fast counter that increments once for each cycle its event input is high. All the remaining high-order bits of every counter are stored in one shared single-port RAM. When bit 6 of a fast counter sets, a small state machine performs a read-modify-write on that counter's RAM word, adding one unit of 64. In the same cycle it clears bit 6 of the fast counter and keeps the low six bits and any increment arriving in that cycle.

Software-side logic sees a plain read request/response port and a write port. A read adds the RAM word and the live fast counter into one full-width value. A write places the upper bits in RAM and the low six bits in the fast counter. Several counters can have folds pending at once. They are served in rotating order, so every fast counter is drained well before it can wrap.

Top module: `pmc_bank`

## Requirements
- R1: After reset every counter reads as zero and `rd_valid` is low.
- R2: Each cycle in which `evt_in[i]` is high adds exactly one to counter i. Events on different counters in the same cycle are all counted.
- R3: Once bit 6 of a fast counter is set, that fold finishes within 64 cycles, so no event is lost, provided `wr_en` is not held high for long stretches.
- R4: A fold keeps the fast counter's low six bits and any increment of the same cycle. The counter's total therefore stays exact across folds.
- R5: A fold grant goes to exactly one counter, and only to a counter whose fold is pending. Pending counters are granted in rotating index order, starting after the last one granted.
- R6: A read request (`rd_en` high for one cycle with `rd_idx`) returns the full count in `rd_data`, with `rd_valid` high for one cycle. The count is the value the counter held in the cycle just before `rd_valid`. With no write and no fold in the way, `rd_valid` rises three cycles after the request cycle.
- R7: A read of a counter is never started while a fold of that same counter is in progress.
- R8: A write (`wr_en`, `wr_idx`, `wr_data`) sets the counter to `wr_data` from the next cycle on. Bits 63:6 go to RAM, and bits 5:0 load the fast counter with bit 6 cleared.
- R9: A write to a counter whose fold is in progress cancels that fold. The counter then holds the written value.
- R10: A write to a counter takes priority over an event on that counter in the same cycle. That event is dropped.
- R11: A counter wraps modulo 2^64 through the fold path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | NUM_CTR | One event strobe per counter |
| rd_en | input | 1 | Read request, one cycle; ignored while a read is outstanding |
| rd_idx | input | IDX_W | Counter to read |
| rd_data | output | CTR_W | Full counter value |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| wr_en | input | 1 | Write strobe, always accepted |
| wr_idx | input | IDX_W | Counter to write |
| wr_data | input | CTR_W | Value to load |

## Verification
A write or an event takes effect in the cycle after the one that drives it. The bench's reference model therefore advances at each edge from the inputs applied in the preceding cycle. A read answer is due at least three cycles after the request, and later when a write or a fold holds the RAM port. So the bench does not wait a fixed delay. It waits for `rd_valid` and compares `rd_data` with the model value snapped one cycle earlier, which is the cycle in which the sum was formed. In the directed idle case, the bench also checks that the delay is exactly three cycles.

// File: rtl/pmc_pkg.sv
// Package: shared types for the performance counter bank.
// Assumes: nothing beyond SystemVerilog 2017.
package pmc_pkg;

    // Fold state machine: idle, data returning from RAM, write-back pending.
    typedef enum logic [1:0] {
        FL_IDLE = 2'd0,
        FL_ADD  = 2'd1,
        FL_WB   = 2'd2
    } fl_state_e;

endpackage

// File: rtl/pmc_fast_ctr.sv
// Module: one per-counter fast register in flops.
// Counts event cycles, can be loaded with the low bits of a write, and
// drops its top bit when the fold engine commits. A load wins over an event.
// Assumes: clr_msb is only raised while the top bit is set.
module pmc_fast_ctr #(
    parameter int LOW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             load,
    input  logic [LOW_W-2:0] load_val,
    input  logic             clr_msb,
    output logic [LOW_W-1:0] cnt,
    output logic             pend
);
    localparam logic [LOW_W:0] UNIT = (LOW_W+1)'(1) << (LOW_W-1);

    logic [LOW_W:0] sum;

    // Next count: increment by the event and take away one unit on a fold.
    always_comb begin
        sum = {1'b0, cnt} + (LOW_W+1)'(evt);
        if (clr_msb) begin
            sum = sum - UNIT;
        end
    end

    // Register update: write load has priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= {1'b0, load_val};
        end else begin
            cnt <= sum[LOW_W-1:0];
        end
    end

    assign pend = cnt[LOW_W-1];

endmodule

// File: rtl/pmc_rr_arb.sv
// Module: rotating-priority picker for pending folds.
// Searches from the entry after the last one granted. The pointer moves only
// when 'take' confirms the grant was used.
// Assumes: NUM >= 2.
module pmc_rr_arb #(
    parameter int NUM   = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM-1:0]   req,
    input  logic             take,
    output logic             any,
    output logic [IDX_W-1:0] gnt_idx,
    output logic [NUM-1:0]   gnt
);
    logic [IDX_W-1:0] last_q;

    // Find the first requester after the last grant, wrapping around.
    always_comb begin
        int cand;
        any     = 1'b0;
        gnt_idx = '0;
        for (int k = 1; k <= NUM; k++) begin
            cand = int'(last_q) + k;
            if (cand >= NUM) begin
                cand = cand - NUM;
            end
            if (!any && req[cand]) begin
                any     = 1'b1;
                gnt_idx = IDX_W'(cand);
            end
        end
        gnt = '0;
        if (any) begin
            gnt[gnt_idx] = 1'b1;
        end
    end

    // Remember the last index actually served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IDX_W'(NUM - 1);
        end else if (take && any) begin
            last_q <= gnt_idx;
        end
    end

endmodule

// File: rtl/pmc_word_ram.sv
// Module: single-port word store for the upper counter bits.
// One access per cycle. Read data is registered and changes only on a read.
// Per-word written flags make never-written words read as zero after reset,
// so no clearing sweep is needed.
// Assumes: en/we/addr are stable around the clock edge.
module pmc_word_ram #(
    parameter int DEPTH  = 4,
    parameter int WIDTH  = 58,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [DEPTH-1:0] known_q;

    // Storage array: written on a write access, no reset.
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
    end

    // Written flags and registered read output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            known_q <= '0;
            rdata   <= '0;
        end else if (en) begin
            if (we) begin
                known_q[addr] <= 1'b1;
            end else begin
                rdata <= known_q[addr] ? mem[addr] : '0;
            end
        end
    end

endmodule

// File: rtl/pmc_bank.sv
// Module: top of the performance counter bank.
// Holds NUM_CTR counters of CTR_W bits. The low LOW_W bits of each sit in a
// fast flop counter and the rest in a shared single-port RAM. A fold engine
// adds one unit into RAM when a fast counter's top bit sets. RAM port
// priority: host write, then fold, then host read.
// Assumes: NUM_CTR >= 2, CTR_W > LOW_W, at most one read outstanding.
module pmc_bank #(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 64,
    parameter int LOW_W   = 7,
    parameter int IDX_W   = $clog2(NUM_CTR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] evt_in,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [CTR_W-1:0]   rd_data,
    output logic               rd_valid,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [CTR_W-1:0]   wr_data
);
    import pmc_pkg::*;

    localparam int SH   = LOW_W - 1;
    localparam int HI_W = CTR_W - SH;

    logic [LOW_W-1:0]       fast_cnt [NUM_CTR];
    logic [NUM_CTR*LOW_W-1:0] fast_flat;
    logic [NUM_CTR-1:0]     pend_vec;
    logic [NUM_CTR-1:0]     gnt_vec;
    logic [NUM_CTR-1:0]     load_vec;
    logic [NUM_CTR-1:0]     clr_vec;
    logic                   any_pend;
    logic [IDX_W-1:0]       gnt_idx;

    fl_state_e              state_q;
    logic [IDX_W-1:0]       fl_idx_q;
    logic [HI_W-1:0]        fl_sum_q;
    logic                   rd_pend_q;
    logic [IDX_W-1:0]       rd_idx_q;
    logic                   rd_resp_q;
    logic [IDX_W-1:0]       rd_resp_idx_q;

    logic                   fl_issue;
    logic                   fl_commit;
    logic                   fl_busy;
    logic                   host_rd_issue;
    logic                   wr_hits_fold;
    logic                   ram_en;
    logic                   ram_we;
    logic [IDX_W-1:0]       ram_addr;
    logic [HI_W-1:0]        ram_wdata;
    logic [HI_W-1:0]        ram_rdata;

    // One fast counter per bank entry.
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_fast
        assign load_vec[g] = wr_en && (wr_idx == IDX_W'(g));
        assign clr_vec[g]  = fl_commit && (fl_idx_q == IDX_W'(g));
        pmc_fast_ctr #(.LOW_W(LOW_W)) u_fast (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt_in[g]),
            .load     (load_vec[g]),
            .load_val (wr_data[SH-1:0]),
            .clr_msb  (clr_vec[g]),
            .cnt      (fast_cnt[g]),
            .pend     (pend_vec[g])
        );
        assign fast_flat[g*LOW_W +: LOW_W] = fast_cnt[g];
    end

    pmc_rr_arb #(.NUM(NUM_CTR), .IDX_W(IDX_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (pend_vec),
        .take    (fl_issue),
        .any     (any_pend),
        .gnt_idx (gnt_idx),
        .gnt     (gnt_vec)
    );

    // RAM port arbitration: write, fold read/write-back, then host read.
    always_comb begin
        fl_busy       = (state_q != FL_IDLE);
        wr_hits_fold  = wr_en && fl_busy && (wr_idx == fl_idx_q);
        fl_issue      = (state_q == FL_IDLE) && !wr_en && any_pend;
        fl_commit     = (state_q == FL_WB) && !wr_en;
        host_rd_issue = rd_pend_q && !wr_en &&
                        (((state_q == FL_IDLE) && !any_pend) ||
                         ((state_q == FL_ADD) && (rd_idx_q != fl_idx_q)));
        ram_en        = wr_en || fl_issue || fl_commit || host_rd_issue;
        ram_we        = wr_en || fl_commit;
        if (wr_en) begin
            ram_addr  = wr_idx;
        end else if (fl_issue) begin
            ram_addr  = gnt_idx;
        end else if (fl_commit) begin
            ram_addr  = fl_idx_q;
        end else begin
            ram_addr  = rd_idx_q;
        end
        ram_wdata     = wr_en ? wr_data[CTR_W-1:SH] : fl_sum_q;
    end

    pmc_word_ram #(.DEPTH(NUM_CTR), .WIDTH(HI_W), .ADDR_W(IDX_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    // Fold state machine: issue read, add one unit, write back or cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= FL_IDLE;
            fl_idx_q <= '0;
            fl_sum_q <= '0;
        end else begin
            case (state_q)
                FL_IDLE: begin
                    if (fl_issue) begin
                        state_q  <= FL_ADD;
                        fl_idx_q <= gnt_idx;
                    end
                end
                FL_ADD: begin
                    fl_sum_q <= ram_rdata + HI_W'(1);
                    state_q  <= wr_hits_fold ? FL_IDLE : FL_WB;
                end
                FL_WB: begin
                    if (wr_hits_fold || !wr_en) begin
                        state_q <= FL_IDLE;
                    end
                end
                default: state_q <= FL_IDLE;
            endcase
        end
    end

    // Host read request capture; new requests ignored while one waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            rd_idx_q  <= '0;
        end else if (host_rd_issue) begin
            rd_pend_q <= 1'b0;
        end else if (rd_en && !rd_pend_q) begin
            rd_pend_q <= 1'b1;
            rd_idx_q  <= rd_idx;
        end
    end

    // Host read response: merge RAM word and live fast counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_resp_q     <= 1'b0;
            rd_resp_idx_q <= '0;
            rd_valid      <= 1'b0;
            rd_data       <= '0;
        end else begin
            rd_resp_q     <= host_rd_issue;
            rd_resp_idx_q <= rd_idx_q;
            rd_valid      <= rd_resp_q;
            if (rd_resp_q) begin
                rd_data <= {ram_rdata, {SH{1'b0}}} +
                           {{(CTR_W-LOW_W){1'b0}}, fast_cnt[rd_resp_idx_q]};
            end
        end
    end

endmodule

// File: rtl/pmc_bank_chk.sv
// Module: property checker for pmc_bank, attached by bind below.
// Watches fold deadlines, grant sanity, read ordering and write effects.
// Assumes: reset is asserted for at least one clock at start.
module pmc_bank_chk #(
    parameter int NUM_CTR = 4,
    parameter int LOW_W   = 7,
    parameter int IDX_W   = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CTR*LOW_W-1:0] fast_flat,
    input logic [NUM_CTR-1:0]       pend_vec,
    input logic [NUM_CTR-1:0]       gnt_vec,
    input logic                     fl_issue,
    input logic                     fl_busy,
    input logic [IDX_W-1:0]         fl_idx_q,
    input logic                     host_rd_issue,
    input logic [IDX_W-1:0]         rd_idx_q,
    input logic                     rd_valid,
    input logic                     wr_en,
    input logic [IDX_W-1:0]         wr_idx,
    input logic [LOW_W-2:0]         wr_low
);
    localparam int LIMIT = 1 << (LOW_W - 1);

    logic [LOW_W:0]   age_q [NUM_CTR];
    logic             wr_q;
    logic [IDX_W-1:0] wr_idx_q;
    logic [LOW_W-2:0] wr_low_q;

    // Age of each pending fold, counted in cycles.
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_age
        always_ff @(posedge clk) begin
            if (!rst_n || !pend_vec[g]) begin
                age_q[g] <= '0;
            end else if (age_q[g] != '1) begin
                age_q[g] <= age_q[g] + 1'b1;
            end
        end
        p_flush_deadline_r3: assert property (@(posedge clk) disable iff (!rst_n)
            int'(age_q[g]) < LIMIT);
    end

    // Remember the last write to check its effect one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            wr_idx_q <= '0;
            wr_low_q <= '0;
        end else begin
            wr_q     <= wr_en;
            wr_idx_q <= wr_idx;
            wr_low_q <= wr_low;
        end
    end

    p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_vec));
    p_grant_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fl_issue |-> ((gnt_vec & ~pend_vec) == '0) && (gnt_vec != '0));
    p_read_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_issue && fl_busy) |-> (rd_idx_q != fl_idx_q));
    p_read_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(host_rd_issue, 2));
    p_write_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fl_busy && (wr_idx == fl_idx_q)) |=> !fl_busy);
    p_write_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> (fast_flat[wr_idx_q*LOW_W +: LOW_W] == {1'b0, wr_low_q}));

endmodule

bind pmc_bank pmc_bank_chk #(
    .NUM_CTR (NUM_CTR),
    .LOW_W   (LOW_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fast_flat     (fast_flat),
    .pend_vec      (pend_vec),
    .gnt_vec       (gnt_vec),
    .fl_issue      (fl_issue),
    .fl_busy       (fl_busy),
    .fl_idx_q      (fl_idx_q),
    .host_rd_issue (host_rd_issue),
    .rd_idx_q      (rd_idx_q),
    .rd_valid      (rd_valid),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_low        (wr_data[LOW_W-2:0])
);

// File: tb/pmc_bank_tb.sv
// Bench for pmc_bank: directed corner cases plus seeded random traffic,
// compared against a cycle-level reference model of the full counters.
module pmc_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int W     = 64;
    localparam int IW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt_in = '0;
    logic          rd_en = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic [W-1:0]  rd_data;
    logic          rd_valid;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [W-1:0]  wr_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [W-1:0] model [N];
    logic [W-1:0] snap  [N];
    bit            rd_out = 1'b0;
    int            rd_sent_idx = 0;
    int            rd_sent_cyc = 0;
    int            want_lat = -1;
    string         cur_tag = "R2";

    always #(CLK_PERIOD/2) clk = ~clk;

    pmc_bank #(.NUM_CTR(N), .CTR_W(W), .LOW_W(7)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    function automatic logic [W-1:0] next_val(logic [W-1:0] cur, bit ev,
                                             bit we, logic [W-1:0] wd);
        // R10: a write wins over an event in the same cycle.
        if (we) return wd;
        return cur + (ev ? 64'd1 : 64'd0);
    endfunction

    task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle, called at a falling edge: check outputs, then drive inputs.
    task automatic tick(logic [N-1:0] ev, bit we, int wi, logic [W-1:0] wd,
                        bit re, int ri);
        if (rd_valid) begin
            if (!rd_out) begin
                check(1'b0, "R6", 64'd1, 64'd0);
            end else begin
                check(rd_data == snap[rd_sent_idx], cur_tag, rd_data, snap[rd_sent_idx]);
                if (want_lat >= 0) begin
                    check((cyc - rd_sent_cyc) == want_lat, "R6",
                          W'(cyc - rd_sent_cyc), W'(want_lat));
                end
                rd_out = 1'b0;
            end
        end
        for (int i = 0; i < N; i++) snap[i] = model[i];
        evt_in  = ev;
        wr_en   = we;
        wr_idx  = IW'(wi);
        wr_data = wd;
        rd_en   = re && !rd_out;
        rd_idx  = IW'(ri);
        if (re && !rd_out) begin
            rd_out      = 1'b1;
            rd_sent_idx = ri;
            rd_sent_cyc = cyc;
        end
        for (int i = 0; i < N; i++)
            model[i] = next_val(model[i], ev[i], we && (wi == i), wd);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) tick('0, 1'b0, 0, '0, 1'b0, 0);
    endtask

    task automatic do_read(int idx, string tag, int lat);
        cur_tag  = tag;
        want_lat = lat;
        tick('0, 1'b0, 0, '0, 1'b1, idx);
        for (int k = 0; k < 300 && rd_out; k++) idle(1);
        if (rd_out) begin
            check(1'b0, tag, 64'd0, 64'd1);
            rd_out = 1'b0;
        end
        want_lat = -1;
    endtask

    initial begin
        int seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        for (int i = 0; i < N; i++) begin model[i] = '0; snap[i] = '0; end
        repeat (4) @(negedge clk);
        // R1: reset state at the ports.
        check(rd_valid == 1'b0, "R1", W'(rd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < N; i++) do_read(i, "R1", 3);

        // R2: simultaneous events on all counters, short burst.
        for (int k = 0; k < 10; k++) tick(4'b1111, 1'b0, 0, '0, 1'b0, 0);
        idle(12);
        do_read(2, "R2", 3);

        // R4: long stream across many folds on one counter.
        for (int k = 0; k < 300; k++) tick(4'b0001, 1'b0, 0, '0, 1'b0, 0);
        idle(12);
        do_read(0, "R4", 3);

        // R5: all counters busy, folds must rotate so totals stay exact.
        for (int k = 0; k < 700; k++) tick(4'b1111, 1'b0, 0, '0, 1'b0, 0);
        idle(20);
        for (int i = 0; i < N; i++) do_read(i, "R5", -1);

        // R8: write then read back.
        tick('0, 1'b1, 3, 64'h0123_4567_89AB_CDEF, 1'b0, 0);
        idle(4);
        do_read(3, "R8", -1);

        // R10: write and event on the same counter in the same cycle.
        tick(4'b0010, 1'b1, 1, 64'd100, 1'b0, 0);
        idle(4);
        do_read(1, "R10", -1);

        // R9: write lands while a fold of the same counter is in flight.
        for (int d = 0; d < 4; d++) begin
            tick('0, 1'b1, 2, 64'd63, 1'b0, 0);
            tick(4'b0100, 1'b0, 0, '0, 1'b0, 0);
            idle(d);
            tick('0, 1'b1, 2, 64'd500 + W'(d), 1'b0, 0);
            idle(6);
            do_read(2, "R9", -1);
        end

        // R11: wrap modulo 2^64 through a fold.
        tick('0, 1'b1, 0, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 0);
        for (int k = 0; k < 40; k++) tick(4'b0001, 1'b0, 0, '0, 1'b0, 0);
        idle(10);
        do_read(0, "R11", -1);

        // R3 / R6 / R7: random mix of events, writes and reads.
        cur_tag = "R3";
        for (int k = 0; k < 6000; k++) begin
            logic [N-1:0] ev;
            bit we;
            bit re;
            logic [W-1:0] wd;
            ev = N'($urandom) & N'($urandom | 32'h5);
            we = ($urandom % 60) == 0;
            re = ($urandom % 3) == 0;
            wd = {$urandom, $urandom};
            if (($urandom % 4) == 0) wd[W-1:8] = '1;
            tick(ev, we, int'($urandom % N), wd, re, int'($urandom % N));
        end
        idle(40);
        for (int i = 0; i < N; i++) do_read(i, "R6", -1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule